// File: doc/BRIEF.md
# Chained DMA channel engine

This block is the sequencing engine of one DMA channel. It runs either a single transfer whose four descriptor words come straight from the channel's configuration inputs, or a linked chain of four-word descriptors that it reads from memory one after another. Each descriptor carries a device address, a memory address, a size word and a link word. The size word packs an element count, an element-width code and reserved bits. The link word carries the address of the next descriptor and two control bits: one says whether to follow the link, the other whether to raise a completion pulse when the descriptor finishes.

The engine fetches descriptor words over a simple read port (request held until acknowledged, data valid with the acknowledge). It hands each element to an external data mover over a request/grant pair that carries source, destination and width. The direction input decides whether the memory address or the device address is the source. The reported state code shows the engine's phase. A one-cycle done pulse marks each descriptor that asked for one, and a one-cycle error pulse marks a rejected descriptor.

Top module: `dmac_chain_engine`

## Requirements
- R1: While reset is held and right after it, state is 0 (idle), no read or mover request is raised and done and error are low.
- R2: A start with mode 2 (single shot) copies the four configuration inputs into the engine and runs that one descriptor without any memory read. The follow bit of its link word is ignored, so the engine returns to idle after it.
- R3: A start with mode 1 (chained) clears the low two bits of the configured link word and reads four words from that address at offsets 0, 4, 8 and 12, in that order, as device address, memory address, size and link. A stalled read keeps its address, and element transfers begin only after the fourth read is acknowledged.
- R4: Size bits [13:12] give the element width: code 3 is 1 byte, code 2 is 2 bytes, code 0 is 4 bytes. The width output is log2 of the byte count (0, 1 or 2). After each granted element, both addresses advance by the width in bytes.
- R5: With direction 1 the mover source is the memory address and the destination is the device address. With direction 0 they are swapped. Direction is captured at start.
- R6: In chained mode, a finished descriptor whose link bit 1 is set makes the engine read the next descriptor at the link word with its low two bits cleared. With bit 1 clear, the engine goes idle.
- R7: Exactly one done pulse, one cycle long, follows the end of each descriptor whose link bit 0 is set. A descriptor with bit 0 clear produces none.
- R8: A descriptor is rejected when its width code is 1, when its count (size bits [11:0]) exceeds 0x3FF for 1- and 2-byte widths or 0x7FF for 4-byte width, or when any size bit [31:14] is set. Rejection gives a single error pulse, no mover request, and a return to idle. A count equal to the maximum is accepted.
- R9: A descriptor with count 0 ends without any mover request, and its link bits still apply.
- R10: A mode input other than 1 or 2 while the engine is busy returns it to idle on the next clock. Requests drop, and no done or error pulse is raised.
- R11: A start while the engine is busy is ignored. A start with mode 0 or 3 leaves the engine idle.
- R12: The state output encodes 0 idle, 1 descriptor read, 2 wait (one cycle, the descriptor check), 3 access (element transfers). A single-shot start goes to 2 and then 3; a chained start goes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| mode_i | input | 2 | 0 off, 1 chained, 2 single shot, 3 off |
| dir_i | input | 1 | 1: memory to device, 0: device to memory |
| cfg_dev_i | input | AW | Device address for single shot |
| cfg_mem_i | input | AW | Memory address for single shot |
| cfg_size_i | input | 32 | Size word for single shot |
| cfg_link_i | input | 32 | Link word (single shot) or first descriptor pointer (chained) |
| rd_req_o | output | 1 | Descriptor read request |
| rd_addr_o | output | AW | Descriptor word address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | 32 | Read data |
| mv_req_o | output | 1 | Element transfer request |
| mv_src_o | output | AW | Element source address |
| mv_dst_o | output | AW | Element destination address |
| mv_wlog_o | output | 2 | log2 of element width in bytes |
| mv_gnt_i | input | 1 | Element transfer granted and done |
| state_o | output | 2 | Engine state code |
| done_o | output | 1 | Descriptor completion pulse |
| err_o | output | 1 | Descriptor rejection pulse |

## Verification
The bench inserts pseudo-random stalls on both handshakes. A fetch that moved its address during a stall, or that started transfers before the last word arrived, would log reads out of order or moves with stale fields. It runs counts at exactly the width maximum and one above it, a zero count in mid-chain, and the reserved width code. A wrong limit compare would either reject the maximum or run the oversized descriptor, and a zero count handled as a normal count would issue a request with a wrapped counter. It also aborts in the middle of a transfer and pulses start while the engine is busy. A leaky abort would keep issuing moves or raise a done pulse, and a start that is not ignored would restart the fetch at the wrong pointer. The single-shot run carries a link word with the follow bit set, which catches an engine that wanders into a fetch after its one descriptor.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam int WORD_W     = 32;
  localparam int CNT_W      = 12;
  localparam int WCODE_LSB  = 12;
  localparam int RSVD_LSB   = 14;
  localparam int DESC_WORDS = 4;

  localparam logic [1:0] MODE_OFF    = 2'd0;
  localparam logic [1:0] MODE_CHAIN  = 2'd1;
  localparam logic [1:0] MODE_SINGLE = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_MOVE  = 2'd3
  } eng_state_e;

  function automatic logic [1:0] size_wcode(input logic [WORD_W-1:0] s);
    return s[WCODE_LSB+1:WCODE_LSB];
  endfunction

  function automatic logic [CNT_W-1:0] size_cnt(input logic [WORD_W-1:0] s);
    return s[CNT_W-1:0];
  endfunction

  // width code -> log2 of bytes per element
  function automatic logic [1:0] wcode_log2(input logic [1:0] c);
    case (c)
      2'd3:    return 2'd0;
      2'd2:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] wcode_limit(input logic [1:0] c);
    return (c == 2'd0) ? CNT_W'(12'h7FF) : CNT_W'(12'h3FF);
  endfunction

  function automatic logic size_bad(input logic [WORD_W-1:0] s);
    logic [1:0] c;
    c = size_wcode(s);
    return (s[WORD_W-1:RSVD_LSB] != '0) || (c == 2'd1) ||
           (size_cnt(s) > wcode_limit(c));
  endfunction

  function automatic logic link_follows(input logic [WORD_W-1:0] l);
    return l[1];
  endfunction

  function automatic logic link_irq(input logic [WORD_W-1:0] l);
    return l[0];
  endfunction

endpackage

// File: rtl/dmac_desc_fetch.sv
module dmac_desc_fetch import dmac_pkg::*; #(
  parameter int AW     = 32,
  parameter int NWORDS = DESC_WORDS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  launch_i,
  input  logic [AW-1:0]         base_i,
  input  logic                  active_i,
  output logic                  rd_req_o,
  output logic [AW-1:0]         rd_addr_o,
  input  logic                  rd_ack_i,
  input  logic [WORD_W-1:0]     rd_data_i,
  output logic [WORD_W-1:0]     words_o [NWORDS],
  output logic                  done_o
);

  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NWORDS - 1);

  logic [IDX_W-1:0] idx_q;
  logic [AW-1:0]    base_q;
  logic             beat;

  assign beat      = active_i && rd_ack_i;
  assign done_o    = beat && (idx_q == IDX_LAST);
  assign rd_req_o  = active_i;
  assign rd_addr_o = base_q + (AW'(idx_q) << 2);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      base_q <= '0;
    end else if (launch_i) begin
      idx_q  <= '0;
      base_q <= {base_i[AW-1:2], 2'b00};
    end else if (beat) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  // words before the last are held; the last one is passed through live
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    if (g < NWORDS - 1) begin : g_held
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk_i) begin
        if (!rst_ni)                                word_q <= '0;
        else if (beat && (idx_q == IDX_W'(g)))      word_q <= rd_data_i;
      end
      assign words_o[g] = word_q;
    end else begin : g_live
      assign words_o[g] = rd_data_i;
    end
  end

  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !rd_ack_i) |=> (!active_i || $stable(rd_addr_o)));

  // R3
  word_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat && !done_o) |=> (!active_i || (rd_addr_o == $past(rd_addr_o) + AW'(4))));

endmodule

// File: rtl/dmac_elem_walk.sv
module dmac_elem_walk import dmac_pkg::*; #(
  parameter int AW = 32,
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] dev_i,
  input  logic [AW-1:0] mem_i,
  input  logic [CW-1:0] count_i,
  input  logic [1:0]    wlog_i,
  input  logic          step_i,
  output logic [AW-1:0] dev_o,
  output logic [AW-1:0] mem_o,
  output logic [1:0]    wlog_o,
  output logic          last_o
);

  logic [AW-1:0] dev_q, mem_q;
  logic [CW-1:0] left_q;
  logic [1:0]    wlog_q;
  logic [AW-1:0] stride;

  assign stride = AW'(1) << wlog_q;
  assign last_o = (left_q == CW'(1));
  assign dev_o  = dev_q;
  assign mem_o  = mem_q;
  assign wlog_o = wlog_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      dev_q  <= '0;
      mem_q  <= '0;
      left_q <= '0;
      wlog_q <= '0;
    end else if (load_i) begin
      dev_q  <= dev_i;
      mem_q  <= mem_i;
      left_q <= count_i;
      wlog_q <= wlog_i;
    end else if (step_i) begin
      dev_q  <= dev_q + stride;
      mem_q  <= mem_q + stride;
      left_q <= left_q - 1'b1;
    end
  end

  // R4
  addr_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> ((mem_o - dev_o) == $past(mem_o - dev_o)));

  // R9
  left_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |-> (left_q != '0));

endmodule

// File: rtl/dmac_chain_engine.sv
module dmac_chain_engine import dmac_pkg::*; #(
  parameter int AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              dir_i,
  input  logic [AW-1:0]     cfg_dev_i,
  input  logic [AW-1:0]     cfg_mem_i,
  input  logic [WORD_W-1:0] cfg_size_i,
  input  logic [WORD_W-1:0] cfg_link_i,
  output logic              rd_req_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              mv_req_o,
  output logic [AW-1:0]     mv_src_o,
  output logic [AW-1:0]     mv_dst_o,
  output logic [1:0]        mv_wlog_o,
  input  logic              mv_gnt_i,
  output logic [1:0]        state_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int NWORDS = DESC_WORDS;

  eng_state_e        state_q, state_d;
  logic [AW-1:0]     cur_dev_q, cur_mem_q;
  logic [WORD_W-1:0] cur_size_q, cur_link_q;
  logic              single_q, dir_q, done_q, err_q;

  logic              run_ok, take_start, in_wait, in_move;
  logic              desc_bad, desc_zero, follow, desc_end, elem_last;
  logic              launch, fetch_done, walk_load, walk_step, w_last;
  logic [AW-1:0]     launch_base, w_dev, w_mem;
  logic [1:0]        w_wlog;
  logic [WORD_W-1:0] fwords [NWORDS];

  // named events
  assign run_ok     = (mode_i == MODE_CHAIN) || (mode_i == MODE_SINGLE);
  assign take_start = start_i && (state_q == ST_IDLE) && run_ok;
  assign in_wait    = (state_q == ST_WAIT);
  assign in_move    = (state_q == ST_MOVE);
  assign desc_bad   = size_bad(cur_size_q);
  assign desc_zero  = (size_cnt(cur_size_q) == '0);
  assign follow     = link_follows(cur_link_q) && !single_q;
  assign walk_step  = in_move && mv_gnt_i;
  assign elem_last  = walk_step && w_last;
  assign desc_end   = (in_wait && !desc_bad && desc_zero) || elem_last;
  assign walk_load  = run_ok && in_wait && !desc_bad && !desc_zero;
  assign launch     = run_ok && ((take_start && (mode_i == MODE_CHAIN)) ||
                                 (desc_end && follow));
  assign launch_base = take_start ? cfg_link_i[AW-1:0] : cur_link_q[AW-1:0];

  dmac_desc_fetch #(.AW(AW), .NWORDS(NWORDS)) u_fetch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .base_i    (launch_base),
    .active_i  (state_q == ST_FETCH),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .rd_ack_i  (rd_ack_i),
    .rd_data_i (rd_data_i),
    .words_o   (fwords),
    .done_o    (fetch_done)
  );

  dmac_elem_walk #(.AW(AW), .CW(CNT_W)) u_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (walk_load),
    .dev_i   (cur_dev_q),
    .mem_i   (cur_mem_q),
    .count_i (size_cnt(cur_size_q)),
    .wlog_i  (wcode_log2(size_wcode(cur_size_q))),
    .step_i  (walk_step),
    .dev_o   (w_dev),
    .mem_o   (w_mem),
    .wlog_o  (w_wlog),
    .last_o  (w_last)
  );

  always_comb begin
    state_d = state_q;
    if (!run_ok) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:  if (start_i) state_d = (mode_i == MODE_CHAIN) ? ST_FETCH : ST_WAIT;
        ST_FETCH: if (fetch_done) state_d = ST_WAIT;
        ST_WAIT: begin
          if (desc_bad)       state_d = ST_IDLE;
          else if (desc_zero) state_d = follow ? ST_FETCH : ST_IDLE;
          else                state_d = ST_MOVE;
        end
        ST_MOVE:  if (elem_last) state_d = follow ? ST_FETCH : ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cur_dev_q  <= '0;
      cur_mem_q  <= '0;
      cur_size_q <= '0;
      cur_link_q <= '0;
      single_q   <= 1'b0;
      dir_q      <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= run_ok && desc_end && link_irq(cur_link_q);
      err_q   <= run_ok && in_wait && desc_bad;
      if (take_start) begin
        single_q <= (mode_i == MODE_SINGLE);
        dir_q    <= dir_i;
        if (mode_i == MODE_SINGLE) begin
          cur_dev_q  <= cfg_dev_i;
          cur_mem_q  <= cfg_mem_i;
          cur_size_q <= cfg_size_i;
          cur_link_q <= cfg_link_i;
        end
      end else if ((state_q == ST_FETCH) && fetch_done) begin
        cur_dev_q  <= fwords[0][AW-1:0];
        cur_mem_q  <= fwords[1][AW-1:0];
        cur_size_q <= fwords[2];
        cur_link_q <= fwords[3];
      end
    end
  end

  assign mv_req_o  = in_move;
  assign mv_src_o  = dir_q ? w_mem : w_dev;
  assign mv_dst_o  = dir_q ? w_dev : w_mem;
  assign mv_wlog_o = w_wlog;
  assign state_o   = state_q;
  assign done_o    = done_q;
  assign err_o     = err_q;

  // R8
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (state_q == ST_IDLE));

  // R8
  err_not_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !done_o);

  // R7
  done_after_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(desc_end));

  // R10
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q != ST_IDLE) && !run_ok) |=> (state_q == ST_IDLE) && !done_o && !err_o);

  // R3
  move_from_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_move && ($past(state_q) != ST_MOVE)) |-> ($past(state_q) == ST_WAIT));

  // R2
  single_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single_q && (state_q != ST_IDLE)) |-> !rd_req_o);

endmodule

// File: tb/test_dmac_chain_engine.sv
module test_dmac_chain_engine;
  localparam int PERIOD = 10;
  localparam int WDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        dir = 1'b0;
  logic [31:0] cfg_dev = '0, cfg_mem = '0, cfg_size = '0, cfg_link = '0;
  logic        rd_req, rd_ack, mv_req, mv_gnt, done, err;
  logic [31:0] rd_addr, rd_data, mv_src, mv_dst;
  logic [1:0]  mv_wlog, state;

  logic [31:0] mem [0:255];
  logic [7:0]  lfsr = 8'hA5;
  logic        rd_en = 1'b0, gnt_en = 1'b0;

  int errors = 0, checks = 0, cyc = 0;
  int rd_n = 0, mv_n = 0, done_n = 0, err_n = 0;
  logic [31:0] rd_log [0:63];
  logic [31:0] mv_src_log [0:4095];
  logic [31:0] mv_dst_log [0:4095];
  logic [1:0]  mv_w_log [0:4095];

  always #(PERIOD/2) clk = ~clk;

  assign rd_ack  = rd_req & rd_en;
  assign rd_data = mem[rd_addr[9:2]];
  assign mv_gnt  = mv_req & gnt_en;

  dmac_chain_engine #(.AW(32)) i_dmac_chain_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .dir_i(dir),
    .cfg_dev_i(cfg_dev), .cfg_mem_i(cfg_mem), .cfg_size_i(cfg_size), .cfg_link_i(cfg_link),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
    .mv_req_o(mv_req), .mv_src_o(mv_src), .mv_dst_o(mv_dst), .mv_wlog_o(mv_wlog),
    .mv_gnt_i(mv_gnt), .state_o(state), .done_o(done), .err_o(err));

  // handshake stalls
  always @(posedge clk) begin
    lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rd_en  <= lfsr[1] | lfsr[2];
    gnt_en <= lfsr[0] | lfsr[4];
  end

  // monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_req && rd_ack) begin
        if (rd_n < 64) rd_log[rd_n] = rd_addr;
        rd_n++;
      end
      if (mv_req && mv_gnt) begin
        if (mv_n < 4096) begin
          mv_src_log[mv_n] = mv_src;
          mv_dst_log[mv_n] = mv_dst;
          mv_w_log[mv_n]   = mv_wlog;
        end
        mv_n++;
      end
      if (done) done_n++;
      if (err)  err_n++;
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WDOG);
      report();
    end
  end

  task automatic chk(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic clr_logs();
    rd_n = 0; mv_n = 0; done_n = 0; err_n = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (state != 2'd0 && n < 20000) begin
      tick();
      n++;
    end
    repeat (3) tick();
  endtask

  function automatic logic [31:0] mk_size(input int wcode, input int count);
    return (32'(wcode) << 12) | 32'(count);
  endfunction

  function automatic int bytes_of(input int wcode);
    return (wcode == 3) ? 1 : (wcode == 2) ? 2 : 4;
  endfunction

  task automatic put_desc(input int at, input logic [31:0] d, input logic [31:0] m,
                          input logic [31:0] s, input logic [31:0] l);
    mem[at/4] = d; mem[at/4+1] = m; mem[at/4+2] = s; mem[at/4+3] = l;
  endtask

  task automatic t_reset();
    chk("R1 state in reset", state == 2'd0, 32'(state), 0);
    chk("R1 requests in reset", !rd_req && !mv_req, {30'd0, rd_req, mv_req}, 0);
    chk("R1 pulses in reset", !done && !err, {30'd0, done, err}, 0);
  endtask

  task automatic t_single();
    clr_logs();
    mode = 2'd2; dir = 1'b1;
    cfg_dev = 32'h1000; cfg_mem = 32'h2000;
    cfg_size = mk_size(2, 3); cfg_link = 32'h0000_0043;
    pulse_start();
    chk("R12 single enters wait", state == 2'd2, 32'(state), 2);
    tick();
    chk("R12 wait then access", state == 2'd3, 32'(state), 3);
    wait_idle();
    chk("R2 no descriptor reads", rd_n == 0, rd_n, 0);
    chk("R2 follow bit ignored, 3 moves", mv_n == 3, mv_n, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R5 dir1 source is memory", mv_src_log[i] == 32'h2000 + 2*i, mv_src_log[i], 32'h2000 + 2*i);
      chk("R4 dir1 dest steps by 2", mv_dst_log[i] == 32'h1000 + 2*i, mv_dst_log[i], 32'h1000 + 2*i);
      chk("R4 width code 2 is log 1", mv_w_log[i] == 2'd1, 32'(mv_w_log[i]), 1);
    end
    chk("R7 single done once", done_n == 1, done_n, 1);
  endtask

  task automatic t_chain();
    int bad;
    logic [31:0] es [5];
    logic [31:0] ed [5];
    logic [1:0]  ew [5];
    clr_logs();
    put_desc(32'h40, 32'h5000, 32'h6000, mk_size(3, 2), 32'h82);
    put_desc(32'h80, 32'h7000, 32'h8000, mk_size(0, 3), 32'hC3);
    put_desc(32'hC0, 32'h9000, 32'hA000, mk_size(2, 0), 32'h01);
    mode = 2'd1; dir = 1'b0; cfg_link = 32'h42;
    pulse_start();
    chk("R12 chained start reads", state == 2'd1, 32'(state), 1);
    while (state != 2'd3) tick();
    cfg_link = 32'h100;
    pulse_start();   // R11 busy start
    wait_idle();
    chk("R3 twelve reads", rd_n == 12, rd_n, 12);
    bad = 0;
    for (int d = 0; d < 3; d++)
      for (int w = 0; w < 4; w++)
        if (rd_log[d*4+w] != 32'h40 + 32'h40*d + 4*w) bad++;
    chk("R3 R6 read addresses in order", bad == 0, bad, 0);
    for (int i = 0; i < 2; i++) begin
      es[i] = 32'h5000 + i; ed[i] = 32'h6000 + i; ew[i] = 2'd0;
    end
    for (int i = 0; i < 3; i++) begin
      es[2+i] = 32'h7000 + bytes_of(0)*i; ed[2+i] = 32'h8000 + bytes_of(0)*i; ew[2+i] = 2'd2;
    end
    chk("R9 zero count adds no moves", mv_n == 5, mv_n, 5);
    bad = 0;
    for (int i = 0; i < 5; i++)
      if (mv_src_log[i] != es[i] || mv_dst_log[i] != ed[i] || mv_w_log[i] != ew[i]) bad++;
    chk("R4 R5 chained moves", bad == 0, bad, 0);
    chk("R7 done for irq links only", done_n == 2, done_n, 2);
    chk("R11 busy start ignored", err_n == 0, err_n, 0);
  endtask

  task automatic t_errors();
    clr_logs();
    put_desc(32'h100, 32'h0, 32'h0, mk_size(1, 1), 32'h1);
    mode = 2'd1; cfg_link = 32'h100;
    pulse_start();
    wait_idle();
    chk("R8 width code 1 rejected", err_n == 1, err_n, 1);
    chk("R8 no move on reject", mv_n == 0, mv_n, 0);
    chk("R8 no done on reject", done_n == 0, done_n, 0);
    chk("R8 idle after reject", state == 2'd0, 32'(state), 0);

    clr_logs();
    put_desc(32'h110, 32'h0, 32'h0, mk_size(3, 1) | 32'h0010_0000, 32'h0);
    cfg_link = 32'h110;
    pulse_start();
    wait_idle();
    chk("R8 reserved size bit rejected", err_n == 1 && mv_n == 0, err_n, 1);

    clr_logs();
    put_desc(32'h120, 32'h0, 32'h0, mk_size(3, 32'h400), 32'h0);
    cfg_link = 32'h120;
    pulse_start();
    wait_idle();
    chk("R8 1-byte count 0x400 rejected", err_n == 1 && mv_n == 0, err_n, 1);

    clr_logs();
    put_desc(32'h130, 32'hC000, 32'hB000, mk_size(2, 32'h3FF), 32'h0);
    dir = 1'b1; cfg_link = 32'h130;
    pulse_start();
    wait_idle();
    chk("R8 2-byte max count accepted", err_n == 0 && mv_n == 1023, mv_n, 1023);
    chk("R4 last 2-byte source", mv_src_log[1022] == 32'hB7FC, mv_src_log[1022], 32'hB7FC);
    chk("R5 last 2-byte dest", mv_dst_log[1022] == 32'hC7FC, mv_dst_log[1022], 32'hC7FC);
    chk("R7 no done with code 0", done_n == 0, done_n, 0);
  endtask

  task automatic t_single_max();
    clr_logs();
    mode = 2'd2; dir = 1'b0;
    cfg_dev = 32'h10000; cfg_mem = 32'h20000;
    cfg_size = mk_size(0, 32'h7FF); cfg_link = 32'h1;
    pulse_start();
    wait_idle();
    chk("R8 4-byte max count accepted", err_n == 0 && mv_n == 2047, mv_n, 2047);
    chk("R5 dir0 source is device", mv_src_log[2046] == 32'h11FF8, mv_src_log[2046], 32'h11FF8);
    chk("R4 4-byte dest step", mv_dst_log[2046] == 32'h21FF8, mv_dst_log[2046], 32'h21FF8);
    chk("R4 width code 0 is log 2", mv_w_log[2046] == 2'd2, 32'(mv_w_log[2046]), 2);
    chk("R7 done once", done_n == 1, done_n, 1);
  endtask

  task automatic t_abort();
    int held;
    clr_logs();
    mode = 2'd2; dir = 1'b1;
    cfg_dev = 32'h300; cfg_mem = 32'h400;
    cfg_size = mk_size(2, 32'h100); cfg_link = 32'h1;
    pulse_start();
    while (mv_n < 5) tick();
    mode = 2'd0;
    tick();
    chk("R10 abort returns to idle", state == 2'd0, 32'(state), 0);
    chk("R10 requests drop", !mv_req && !rd_req, {30'd0, mv_req, rd_req}, 0);
    tick();
    held = mv_n;
    repeat (20) tick();
    chk("R10 no moves after abort", mv_n == held, mv_n, held);
    chk("R10 no pulses after abort", done_n == 0 && err_n == 0, done_n + err_n, 0);
  endtask

  task automatic t_off_start();
    clr_logs();
    mode = 2'd0; cfg_link = 32'h40;
    pulse_start();
    chk("R11 mode 0 start ignored", state == 2'd0, 32'(state), 0);
    mode = 2'd3;
    pulse_start();
    chk("R11 mode 3 start ignored", state == 2'd0, 32'(state), 0);
    repeat (5) tick();
    chk("R11 no activity", rd_n == 0 && mv_n == 0, rd_n + mv_n, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_single();
    t_chain();
    t_errors();
    t_single_max();
    t_abort();
    t_off_start();
    report();
  end

endmodule